// File: doc/BRIEF.md
# Audio ADC Clock-Mode Power-Up Sequencer

This controller brings a serial audio converter out of power-down. It runs entirely on the converter's master clock. After reset it holds the reference off and the filters in reset until it has seen a short run of master-clock edges. It then reads a strap pin once to choose whether it is clock master or clock slave.

As master, it waits a fixed initialization interval and then enables the reference. At the same moment it starts driving a frame clock at the master clock divided by 256 and a bit clock at the master clock divided by 4. As slave, it takes the frame clock from outside. It resynchronizes that clock into the master-clock domain and measures one full frame period between two synchronized rising edges. It accepts the period only if it lies near 256, 384 or 512. A period outside those windows is discarded and the next period is measured.

In both modes the serial data line is held at a static level while the filters settle. The level is low for master and high for slave. Settling lasts a parameterized number of frame periods, 11,265 by default. After that, ready rises and the data hold is released. All pins are plain control and status levels; the block has no data stream and no handshake.

Top module: `adc_pwrup_seq`

## Requirements
- R1: While reset is asserted: ref_en=0, ready=0, sdata_hold=1, sdata_level=0, clk_oe=0, lrck_out=0 and ratio_code=00.
- R2: The mode is taken from strap_pd on the ACT_CYCLES-th (default 4) rising mclk edge after reset release. strap_pd=1 (pull-down present) selects slave and strap_pd=0 selects master. Later changes of strap_pd have no effect on any output until the next reset.
- R3: In master mode, ref_en and clk_oe rise on rising mclk edge ACT_CYCLES+LRCK_START (default 4+127=131) after reset release, and ratio_code reads 01.
- R4: In master mode, lrck_out starts low when ref_en rises, has a period of 256 mclk cycles with equal high and low halves, and first rises 128 cycles after ref_en. sclk_out is mclk/4 and first rises 2 cycles after ref_en.
- R5: In slave mode, the number of mclk cycles between two consecutive synchronized lrck_in rising edges is classified. 256±2 gives ratio_code 01, 384±2 gives 10, and 512±2 gives 11. ref_en rises together with the code.
- R6: In slave mode, a measured period outside all three windows leaves ratio_code=00 and ref_en=0. Settling does not start, and the period that follows is measured again.
- R7: From the mode decision until ready, sdata_hold=1, with sdata_level=0 in master mode and 1 in slave mode.
- R8: After ref_en rises, ready rises on the mclk cycle after the SETTLE_PERIODS-th completed frame period, and sdata_hold falls with it. A frame period completes when the master divider wraps, or at a synchronized lrck_in rising edge in slave mode.
- R9: Once high, ready stays high until reset.
- R10: In slave mode, clk_oe stays 0 and lrck_out stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock; sole clock of the block |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_pd | input | 1 | Mode strap, 1 = pull-down sensed (slave) |
| lrck_in | input | 1 | External frame clock, used in slave mode |
| lrck_out | output | 1 | Generated frame clock (master mode) |
| sclk_out | output | 1 | Generated bit clock (master mode) |
| clk_oe | output | 1 | Drive enable for the frame and bit clock pads |
| ratio_code | output | 2 | 00 none, 01 = 256, 10 = 384, 11 = 512 |
| ref_en | output | 1 | Reference enable |
| sdata_hold | output | 1 | Serial data held static while high |
| sdata_level | output | 1 | Static level for serial data during hold |
| ready | output | 1 | Settling complete, data output enabled |

## Verification
The bench walks slave periods at and just past each tolerance edge. A classifier with an off-by-one window would accept 259 or reject 254 and 258. A period of 300 followed by a valid one shows whether the meter re-arms after a rejection; a meter that stalls would never raise ref_en. In master mode the bench counts edges to the exact cycle of ref_en, the first frame clock rise and the first bit clock rise, which exposes a miscounted start delay or a divider tapped at the wrong bit. It also flips the strap after the decision, which a design that keeps sampling the strap would reflect in sdata_level. The settle count is checked one period short and exactly at the end, which catches a settle counter that is off by one in either direction.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_MINIT,
    ST_SMEAS,
    ST_SETTLE,
    ST_RUN
  } seq_state_t;

  localparam logic [1:0] RC_NONE = 2'b00;
  localparam logic [1:0] RC_256  = 2'b01;
  localparam logic [1:0] RC_384  = 2'b10;
  localparam logic [1:0] RC_512  = 2'b11;

  function automatic logic near(input int unsigned p, input int unsigned c, input int unsigned tol);
    return (p + tol >= c) && (p <= c + tol);
  endfunction

  // Maps a measured frame period to a ratio code; RC_NONE when no window matches.
  function automatic logic [1:0] classify(input int unsigned p, input int unsigned tol);
    if (near(p, 256, tol)) return RC_256;
    if (near(p, 384, tol)) return RC_384;
    if (near(p, 512, tol)) return RC_512;
    return RC_NONE;
  endfunction

endpackage

// File: rtl/lrck_edge_sync.sv
module lrck_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  // sh[0..STAGES-1] are synchronizer flops, sh[STAGES] is the edge-history flop
  logic [STAGES:0] sh;

  genvar g;
  generate
    for (g = 0; g <= STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) sh[0] <= 1'b0;
          else        sh[0] <= din;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) sh[g] <= 1'b0;
          else        sh[g] <= sh[g-1];
      end
    end
  endgenerate

  assign rise = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/ratio_meter.sv
module ratio_meter
  import adcseq_pkg::*;
#(
  parameter int CNT_W = 10,
  parameter int TOL   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       rise,
  output logic       hit,
  output logic [1:0] code
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             armed;
  logic [CNT_W-1:0] mcnt;

  // mcnt restarts at 1 on each edge, so at the next edge it equals the period
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      mcnt  <= '0;
    end else if (!en) begin
      armed <= 1'b0;
      mcnt  <= '0;
    end else if (rise) begin
      armed <= 1'b1;
      mcnt  <= CNT_W'(1);
    end else if (mcnt != CNT_MAX) begin
      mcnt  <= mcnt + 1'b1;
    end
  end

  assign code = classify(int'(mcnt), TOL);
  assign hit  = en && rise && armed && (code != RC_NONE);
endmodule

// File: rtl/master_clkgen.sv
module master_clkgen #(
  parameter int DIV      = 256,
  parameter int SCLK_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic lrck,
  output logic sclk,
  output logic wrap
);
  localparam int DIV_W    = $clog2(DIV);
  localparam int SCLK_BIT = $clog2(SCLK_DIV) - 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(DIV - 1);

  logic [DIV_W-1:0] div;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               div <= '0;
    else if (!en)             div <= '0;
    else if (div == DIV_LAST) div <= '0;
    else                      div <= div + 1'b1;
  end

  assign lrck = div[DIV_W-1];
  assign sclk = div[SCLK_BIT];
  assign wrap = en && (div == DIV_LAST);

  // frame clock may only fall where the divider has just wrapped
  p_lrck_fall_at_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lrck) |-> $past(wrap));
endmodule

// File: rtl/adc_pwrup_seq.sv
module adc_pwrup_seq
  import adcseq_pkg::*;
#(
  parameter int ACT_CYCLES     = 4,
  parameter int LRCK_START     = 127,
  parameter int MASTER_DIV     = 256,
  parameter int SCLK_DIV       = 4,
  parameter int SETTLE_PERIODS = 11265,
  parameter int RATIO_TOL      = 2,
  parameter int SYNC_STAGES    = 2
) (
  input  logic       mclk,
  input  logic       rst_n,
  input  logic       strap_pd,
  input  logic       lrck_in,
  output logic       lrck_out,
  output logic       sclk_out,
  output logic       clk_oe,
  output logic [1:0] ratio_code,
  output logic       ref_en,
  output logic       sdata_hold,
  output logic       sdata_level,
  output logic       ready
);
  localparam int ACT_W  = $clog2(ACT_CYCLES + 1);
  localparam int INIT_W = $clog2(LRCK_START + 1);
  localparam int SET_W  = $clog2(SETTLE_PERIODS + 1);
  localparam int MCNT_W = $clog2(512 + RATIO_TOL + 2);
  localparam logic [ACT_W-1:0]  ACT_LAST  = ACT_W'(ACT_CYCLES - 1);
  localparam logic [INIT_W-1:0] INIT_LAST = INIT_W'(LRCK_START - 1);
  localparam logic [SET_W-1:0]  SET_LAST  = SET_W'(SETTLE_PERIODS - 1);

  seq_state_t  state;
  logic        slave_q, ref_q, ready_q;
  logic [1:0]  code_q;
  logic [ACT_W-1:0]  act_cnt;
  logic [INIT_W-1:0] init_cnt;
  logic [SET_W-1:0]  per_cnt;

  logic       lrck_rise, meas_hit, m_wrap, m_lrck, m_sclk, tick;
  logic [1:0] meas_code;

  lrck_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(mclk), .rst_n(rst_n), .din(lrck_in), .rise(lrck_rise)
  );

  ratio_meter #(.CNT_W(MCNT_W), .TOL(RATIO_TOL)) u_meter (
    .clk(mclk), .rst_n(rst_n), .en(state == ST_SMEAS), .rise(lrck_rise),
    .hit(meas_hit), .code(meas_code)
  );

  master_clkgen #(.DIV(MASTER_DIV), .SCLK_DIV(SCLK_DIV)) u_clkgen (
    .clk(mclk), .rst_n(rst_n), .en(ref_q && !slave_q),
    .lrck(m_lrck), .sclk(m_sclk), .wrap(m_wrap)
  );

  assign tick = slave_q ? lrck_rise : m_wrap;

  always_ff @(posedge mclk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_OFF;
      slave_q  <= 1'b0;
      ref_q    <= 1'b0;
      ready_q  <= 1'b0;
      code_q   <= RC_NONE;
      act_cnt  <= '0;
      init_cnt <= '0;
      per_cnt  <= '0;
    end else begin
      case (state)
        ST_OFF: begin
          if (act_cnt == ACT_LAST) begin
            slave_q <= strap_pd;
            code_q  <= strap_pd ? RC_NONE : RC_256;
            state   <= strap_pd ? ST_SMEAS : ST_MINIT;
          end else begin
            act_cnt <= act_cnt + 1'b1;
          end
        end
        ST_MINIT: begin
          if (init_cnt == INIT_LAST) begin
            ref_q <= 1'b1;
            state <= ST_SETTLE;
          end else begin
            init_cnt <= init_cnt + 1'b1;
          end
        end
        ST_SMEAS: begin
          if (meas_hit) begin
            code_q <= meas_code;
            ref_q  <= 1'b1;
            state  <= ST_SETTLE;
          end
        end
        ST_SETTLE: begin
          if (tick) begin
            if (per_cnt == SET_LAST) begin
              ready_q <= 1'b1;
              state   <= ST_RUN;
            end else begin
              per_cnt <= per_cnt + 1'b1;
            end
          end
        end
        ST_RUN:  ;
        default: state <= ST_OFF;
      endcase
    end
  end

  assign lrck_out    = m_lrck;
  assign sclk_out    = m_sclk;
  assign clk_oe      = ref_q && !slave_q;
  assign ratio_code  = code_q;
  assign ref_en      = ref_q;
  assign sdata_hold  = !ready_q;
  assign sdata_level = slave_q;
  assign ready       = ready_q;

  p_mode_frozen_r2: assert property (@(posedge mclk) disable iff (!rst_n)
    (state != ST_OFF) |=> $stable(slave_q));
  p_code_with_ref_r5: assert property (@(posedge mclk) disable iff (!rst_n)
    ref_q |-> (code_q != RC_NONE));
  p_ready_after_ref_r8: assert property (@(posedge mclk) disable iff (!rst_n)
    ready_q |-> ref_q);
  p_ready_sticky_r9: assert property (@(posedge mclk) disable iff (!rst_n)
    ready_q |=> ready_q);
  p_slave_quiet_r10: assert property (@(posedge mclk) disable iff (!rst_n)
    slave_q |-> !m_lrck);
endmodule

// File: tb/adc_pwrup_seq_tb_top.sv
module adc_pwrup_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SETTLE_N   = 4;
  localparam int NVEC       = 10;
  localparam int VPER  [NVEC] = '{256, 254, 258, 259, 384, 386, 381, 512, 510, 300};
  localparam int VCODE [NVEC] = '{1,   1,   1,   0,   2,   2,   0,   3,   3,   0};

  logic       mclk = 1'b0;
  logic       rst_n = 1'b0;
  logic       strap_pd = 1'b0;
  logic       lrck_in = 1'b0;
  logic       lrck_out, sclk_out, clk_oe, ref_en, sdata_hold, sdata_level, ready;
  logic [1:0] ratio_code;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) mclk = ~mclk;

  adc_pwrup_seq #(.SETTLE_PERIODS(SETTLE_N)) dut_i (
    .mclk(mclk), .rst_n(rst_n), .strap_pd(strap_pd), .lrck_in(lrck_in),
    .lrck_out(lrck_out), .sclk_out(sclk_out), .clk_oe(clk_oe),
    .ratio_code(ratio_code), .ref_en(ref_en), .sdata_hold(sdata_hold),
    .sdata_level(sdata_level), .ready(ready)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge mclk);
  endtask

  task automatic do_reset(input logic s);
    @(negedge mclk);
    rst_n = 1'b0; strap_pd = s; lrck_in = 1'b0;
    cyc(3);
    rst_n = 1'b1;
  endtask

  task automatic periods(input int p, input int n);
    for (int i = 0; i < n; i++) begin
      lrck_in = 1'b1; cyc(p / 2);
      lrck_in = 1'b0; cyc(p - p / 2);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // R1 reset state, sampled while reset is held
    cyc(2);
    chk("R1 ref_en", ref_en, 0);
    chk("R1 ready", ready, 0);
    chk("R1 sdata_hold", sdata_hold, 1);
    chk("R1 sdata_level", sdata_level, 0);
    chk("R1 clk_oe", clk_oe, 0);
    chk("R1 lrck_out", lrck_out, 0);
    chk("R1 ratio_code", ratio_code, 0);

    // R5 R6 slave classification table
    for (int v = 0; v < NVEC; v++) begin
      do_reset(1'b1);
      cyc(10);
      periods(VPER[v], 2);
      chk($sformatf("R5/R6 code p=%0d", VPER[v]), ratio_code, VCODE[v]);
      chk($sformatf("R5/R6 ref_en p=%0d", VPER[v]), ref_en, VCODE[v] != 0);
    end

    // R6 re-measure after a rejected period
    do_reset(1'b1);
    cyc(10);
    periods(300, 2);
    chk("R6 rejected ref_en", ref_en, 0);
    chk("R6 rejected code", ratio_code, 0);
    periods(256, 2);
    chk("R6 retry ref_en", ref_en, 1);
    chk("R6 retry code", ratio_code, 1);

    // slave settle: R7 R8 R9 R10
    do_reset(1'b1);
    cyc(10);
    chk("R7 slave level pre", sdata_level, 1);
    chk("R7 slave hold pre", sdata_hold, 1);
    periods(384, 2);
    chk("R5 slave 384 code", ratio_code, 2);
    chk("R10 slave clk_oe", clk_oe, 0);
    chk("R10 slave lrck_out", lrck_out, 0);
    periods(384, SETTLE_N - 1);
    chk("R8 slave ready early", ready, 0);
    chk("R7 slave hold settle", sdata_hold, 1);
    chk("R7 slave level settle", sdata_level, 1);
    periods(384, 1);
    chk("R8 slave ready", ready, 1);
    chk("R8 slave hold released", sdata_hold, 0);
    cyc(500);
    chk("R9 ready sticky", ready, 1);
    do_reset(1'b1);
    chk("R1 ready cleared", ready, 0);

    // master: R2 R3 R4 R7 R8
    do_reset(1'b0);
    cyc(10);
    strap_pd = 1'b1;                 // R2 late strap change must be ignored
    cyc(120);                        // 130 edges since release
    chk("R3 ref_en before", ref_en, 0);
    chk("R3 clk_oe before", clk_oe, 0);
    chk("R7 master level", sdata_level, 0);
    cyc(1);                          // edge 131
    chk("R3 ref_en", ref_en, 1);
    chk("R3 clk_oe", clk_oe, 1);
    chk("R3 ratio_code", ratio_code, 1);
    chk("R4 lrck start low", lrck_out, 0);
    chk("R4 sclk start low", sclk_out, 0);
    cyc(2);                          // edge 133
    chk("R4 sclk first rise", sclk_out, 1);
    cyc(125);                        // edge 258
    chk("R4 lrck before rise", lrck_out, 0);
    cyc(1);                          // edge 259
    chk("R4 lrck first rise", lrck_out, 1);
    cyc(127);                        // edge 386
    chk("R4 lrck high half", lrck_out, 1);
    cyc(1);                          // edge 387
    chk("R4 lrck falls", lrck_out, 0);
    cyc(767);                        // edge 1154
    chk("R8 master ready early", ready, 0);
    chk("R7 master hold", sdata_hold, 1);
    cyc(1);                          // edge 1155
    chk("R8 master ready", ready, 1);
    chk("R8 master hold released", sdata_hold, 0);
    chk("R2 strap ignored level", sdata_level, 0);
    chk("R2 strap ignored clk_oe", clk_oe, 1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule